// File: doc/BRIEF.md
# Bus Register Access Handshake

This block sequences single-byte register accesses between a fast bus clock domain and a slower internal clock domain. A bus master opens an access by pulling the active-low address strobe low while the active-low slave select is low. The block captures the register index, the direction and the transfer size, and raises a request flag that crosses into the internal domain through a two-flop synchronizer. There, exactly one read or write strobe, one internal cycle wide, is produced if the size is a single byte.

The falling edge of that internal pulse sets a completion flag, which crosses back into the bus domain. It opens a two-cycle acknowledge window with the output enable high. In the first cycle the acknowledge code says data or error, and in the second cycle it is driven to idle. An access with an illegal size still completes the round trip, but it produces no register strobe and returns the error code. Read data is chosen from the register inputs through a chain of two-input multiplexers selected by the captured index. After reset, a chain fed with a constant one must fill before any access is accepted.

Top module: `bus_reg_handshake`

## Requirements
- R1: An access is accepted only in a bus cycle where `as_n` is sampled low after being sampled high in the previous cycle while `sel_n` is low. A falling `as_n` with `sel_n` high, or `sel_n` going low while `as_n` is already low, starts nothing.
- R2: An accepted access with `size` equal to 2'b00 (single byte) produces exactly one strobe, one `iclk` cycle wide. The strobe is `reg_rd` when `rd_nwr` was 1 and `reg_wr` when it was 0, with `reg_idx` equal to the captured `addr`. The two strobes are never high together.
- R3: An accepted access with any other `size` produces no strobe and returns acknowledge code 3'b010 (error).
- R4: A legal access returns acknowledge code 3'b110 (data), and only after its strobe has ended.
- R5: Each acknowledge holds `ack_oe` high for exactly two consecutive bus cycles. The code is valid in the first cycle and 3'b111 (idle) in the second. `ack_code` is 3'b111 whenever `ack_oe` is low.
- R6: For the first PU_LEN bus cycles after `brst_n` releases, `ack_oe` stays low and strobe edges are ignored.
- R7: A strobe edge arriving before the previous acknowledge has finished and its return flag has cleared is ignored.
- R8: `bus_rdata` equals the `reg_rdata` slice at bits [idx*8 +: 8] for the index captured at acceptance.
- R9: In reset `reg_rd` and `reg_wr` are 0, `ack_oe` is 0 and `ack_code` is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus domain reset, active low |
| as_n | input | 1 | Address strobe, active low |
| sel_n | input | 1 | Slave select, active low |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| size | input | 2 | Transfer size, 2'b00 = byte |
| addr | input | ADDR_W | Register index |
| reg_rdata | input | NUM_REGS*DATA_W | Flattened register read values |
| bus_rdata | output | DATA_W | Read data chosen by captured index |
| ack_code | output | 3 | Acknowledge code (111 idle, 110 data, 010 error) |
| ack_oe | output | 1 | Acknowledge driver enable |
| iclk | input | 1 | Internal clock |
| irst_n | input | 1 | Internal domain reset, active low |
| reg_rd | output | 1 | Register read strobe (iclk) |
| reg_wr | output | 1 | Register write strobe (iclk) |
| reg_idx | output | ADDR_W | Register index for the strobe |

## Verification
The hardest conditions to reach are a second strobe edge that lands while an access is still crossing the two domains, and an edge that lands before the power-up chain has filled. Neither is visible at the ports unless it wrongly produces an extra strobe or acknowledge. The stimulus issues an access in the first bus cycle after reset, and issues a second falling strobe a few bus cycles after an accepted one, well inside the synchronizer round trip. The behavioural model then demands that no extra acknowledge or strobe appears.

// File: rtl/bhs_pkg.sv
package bhs_pkg;
    typedef enum logic [2:0] {
        ACK_IDLE = 3'b111,
        ACK_DATA = 3'b110,
        ACK_ERR  = 3'b010
    } ack_code_e;

    localparam logic [1:0] SIZE_BYTE = 2'b00;
endpackage

// File: rtl/bhs_sync.sv
module bhs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/bhs_bus_ctl.sv
module bhs_bus_ctl
    import bhs_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int PU_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              sel_n,
    input  logic              rd_nwr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic              done_s,
    output logic              req,
    output logic              size_ok,
    output logic              is_rd,
    output logic [ADDR_W-1:0] idx,
    output logic [2:0]        ack_code,
    output logic              ack_oe
);
    localparam logic [1:0] PH_IDLE = 2'd0;
    localparam logic [1:0] PH_CODE = 2'd1;
    localparam logic [1:0] PH_HOLD = 2'd2;

    typedef struct packed {
        logic              as_q;
        logic [PU_LEN-1:0] pu;
        logic              req;
        logic              busy;
        logic              ok;
        logic              rd;
        logic [ADDR_W-1:0] idx;
        logic              done_q;
        logic [1:0]        ph;
    } st_t;

    st_t r_d, r_q;
    logic pwr_ok, start, done_rise;

    always_comb begin
        r_d       = r_q;
        pwr_ok    = r_q.pu[PU_LEN-1];
        start     = pwr_ok && r_q.as_q && !as_n && !sel_n && !r_q.busy;
        done_rise = done_s && !r_q.done_q;

        r_d.as_q   = as_n;
        r_d.pu     = {r_q.pu[PU_LEN-2:0], 1'b1};
        r_d.done_q = done_s;

        if (start) begin
            r_d.req  = 1'b1;
            r_d.busy = 1'b1;
            r_d.ok   = (size == SIZE_BYTE);
            r_d.rd   = rd_nwr;
            r_d.idx  = addr;
        end

        case (r_q.ph)
            PH_IDLE: begin
                if (r_q.req && done_rise) begin
                    r_d.ph  = PH_CODE;
                    r_d.req = 1'b0;
                end else if (r_q.busy && !r_q.req && !done_s) begin
                    r_d.busy = 1'b0;
                end
            end
            PH_CODE: r_d.ph = PH_HOLD;
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.as_q <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req      = r_q.req;
    assign size_ok  = r_q.ok;
    assign is_rd    = r_q.rd;
    assign idx      = r_q.idx;
    assign ack_oe   = (r_q.ph != PH_IDLE);
    assign ack_code = (r_q.ph == PH_CODE) ? (r_q.ok ? ACK_DATA : ACK_ERR) : ACK_IDLE;
endmodule

// File: rtl/bhs_int_ctl.sv
module bhs_int_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic size_ok,
    input  logic is_rd,
    output logic reg_rd,
    output logic reg_wr,
    output logic done
);
    typedef struct packed {
        logic req_q;
        logic pulse;
        logic done;
    } st_t;

    st_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.req_q = req_s;
        r_d.pulse = req_s && !r_q.req_q;
        if (r_q.pulse) begin
            r_d.done = 1'b1;
        end
        if (!req_s) begin
            r_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rd = r_q.pulse && size_ok && is_rd;
    assign reg_wr = r_q.pulse && size_ok && !is_rd;
    assign done   = r_q.done;
endmodule

// File: rtl/bhs_rd_chain.sv
module bhs_rd_chain #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2
) (
    input  logic [NUM_REGS*DATA_W-1:0] data,
    input  logic [ADDR_W-1:0]          idx,
    output logic [DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] link [NUM_REGS+1];

    assign link[0] = '0;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_link
        assign link[g+1] = (idx == ADDR_W'(g)) ? data[g*DATA_W +: DATA_W] : link[g];
    end

    assign rdata = link[NUM_REGS];
endmodule

// File: rtl/bus_reg_handshake.sv
module bus_reg_handshake #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int PU_LEN   = 4,
    localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       bclk,
    input  logic                       brst_n,
    input  logic                       as_n,
    input  logic                       sel_n,
    input  logic                       rd_nwr,
    input  logic [1:0]                 size,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_REGS*DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [2:0]                 ack_code,
    output logic                       ack_oe,
    input  logic                       iclk,
    input  logic                       irst_n,
    output logic                       reg_rd,
    output logic                       reg_wr,
    output logic [ADDR_W-1:0]          reg_idx
);
    logic              req_b, req_i, done_i, done_b;
    logic              ok_b, rd_b;
    logic [ADDR_W-1:0] idx_b;

    bhs_bus_ctl #(.ADDR_W(ADDR_W), .PU_LEN(PU_LEN)) u_bus (
        .clk(bclk), .rst_n(brst_n), .as_n(as_n), .sel_n(sel_n),
        .rd_nwr(rd_nwr), .size(size), .addr(addr), .done_s(done_b),
        .req(req_b), .size_ok(ok_b), .is_rd(rd_b), .idx(idx_b),
        .ack_code(ack_code), .ack_oe(ack_oe)
    );

    bhs_sync #(.W(1)) u_req_sync (
        .clk(iclk), .rst_n(irst_n), .d(req_b), .q(req_i)
    );

    bhs_int_ctl u_int (
        .clk(iclk), .rst_n(irst_n), .req_s(req_i), .size_ok(ok_b),
        .is_rd(rd_b), .reg_rd(reg_rd), .reg_wr(reg_wr), .done(done_i)
    );

    bhs_sync #(.W(1)) u_done_sync (
        .clk(bclk), .rst_n(brst_n), .d(done_i), .q(done_b)
    );

    bhs_rd_chain #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chain (
        .data(reg_rdata), .idx(idx_b), .rdata(bus_rdata)
    );

    assign reg_idx = idx_b;
endmodule

// File: rtl/bhs_checker.sv
module bhs_checker #(
    parameter int PU_LEN = 4
) (
    input logic       bclk,
    input logic       brst_n,
    input logic       iclk,
    input logic       irst_n,
    input logic       ack_oe,
    input logic [2:0] ack_code,
    input logic       reg_rd,
    input logic       reg_wr
);
    int unsigned since_rst_q;

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            since_rst_q <= 0;
        end else if (since_rst_q < PU_LEN + 1) begin
            since_rst_q <= since_rst_q + 1;
        end
    end

    assert_oe_second_R5: assert property (@(posedge bclk) disable iff (!brst_n)
        $rose(ack_oe) |=> ack_oe);

    assert_oe_drops_R5: assert property (@(posedge bclk) disable iff (!brst_n)
        (ack_oe && $past(ack_oe)) |=> !ack_oe);

    assert_code_needs_oe_R5: assert property (@(posedge bclk) disable iff (!brst_n)
        (ack_code != 3'b111) |-> ack_oe);

    assert_hold_idle_R5: assert property (@(posedge bclk) disable iff (!brst_n)
        (ack_oe && $past(ack_oe)) |-> (ack_code == 3'b111));

    assert_quiet_start_R6: assert property (@(posedge bclk) disable iff (!brst_n)
        (since_rst_q < PU_LEN) |-> !ack_oe);

    assert_excl_strobe_R2: assert property (@(posedge iclk) disable iff (!irst_n)
        !(reg_rd && reg_wr));

    assert_single_strobe_R2: assert property (@(posedge iclk) disable iff (!irst_n)
        (reg_rd || reg_wr) |=> !(reg_rd || reg_wr));
endmodule

bind bus_reg_handshake bhs_checker #(.PU_LEN(PU_LEN)) chk_i (
    .bclk(bclk), .brst_n(brst_n), .iclk(iclk), .irst_n(irst_n),
    .ack_oe(ack_oe), .ack_code(ack_code), .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/bus_reg_handshake_tb.sv
module bus_reg_handshake_tb_top;
    localparam int BCLK_PERIOD = 10;
    localparam int ICLK_PERIOD = 40;
    localparam int NUM_REGS    = 4;
    localparam int DATA_W      = 8;
    localparam int PU_LEN      = 4;

    logic        bclk = 1'b0, iclk = 1'b0;
    logic        brst_n = 1'b0, irst_n = 1'b0;
    logic        as_n = 1'b1, sel_n = 1'b1, rd_nwr = 1'b1;
    logic [1:0]  size = 2'b00, addr = 2'b00;
    logic [31:0] reg_rdata = 32'hD4C3B2A1;
    logic [7:0]  bus_rdata;
    logic [2:0]  ack_code;
    logic        ack_oe, reg_rd, reg_wr;
    logic [1:0]  reg_idx;

    always #(BCLK_PERIOD/2) bclk = ~bclk;
    always #(ICLK_PERIOD/2) iclk = ~iclk;

    bus_reg_handshake #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PU_LEN(PU_LEN)) dut_i (
        .bclk(bclk), .brst_n(brst_n), .as_n(as_n), .sel_n(sel_n), .rd_nwr(rd_nwr),
        .size(size), .addr(addr), .reg_rdata(reg_rdata), .bus_rdata(bus_rdata),
        .ack_code(ack_code), .ack_oe(ack_oe), .iclk(iclk), .irst_n(irst_n),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx)
    );

    int total = 0, bad = 0;
    int acks = 0, accepted = 0, legal = 0, strobes = 0;
    int exp_code_q[$], exp_data_q[$], exp_strb_q[$];
    int exp_kind_q[$], exp_idx_q[$];
    int mphase = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference of the acknowledge window, compared every bus clock
    always @(negedge bclk) begin
        if (brst_n) begin
            case (mphase)
                0: begin
                    if (ack_oe) begin
                        acks++;
                        if (exp_code_q.size() == 0) begin
                            chk(0, "R1/R7 unexpected ack", 1, 0);
                        end else begin
                            int c, d, s;
                            c = exp_code_q.pop_front();
                            d = exp_data_q.pop_front();
                            s = exp_strb_q.pop_front();
                            chk(int'(ack_code) == c, (c == 6) ? "R4 data code" : "R3 error code", ack_code, c);
                            chk(int'(bus_rdata) == d, "R8 read data", bus_rdata, d);
                            chk(strobes == s, "R2/R3 strobe count at ack", strobes, s);
                        end
                        mphase = 1;
                    end else if (ack_code != 3'b111) begin
                        chk(0, "R5 code while oe low", ack_code, 7);
                    end
                end
                1: begin
                    chk(ack_oe == 1'b1, "R5 oe second cycle", ack_oe, 1);
                    chk(ack_code == 3'b111, "R5 idle in second cycle", ack_code, 7);
                    mphase = 2;
                end
                default: begin
                    chk(ack_oe == 1'b0, "R5 oe released", ack_oe, 0);
                    mphase = 0;
                end
            endcase
        end
    end

    // strobe observer in the internal domain
    always @(negedge iclk) begin
        if (irst_n && (reg_rd || reg_wr)) begin
            strobes++;
            if (exp_kind_q.size() == 0) begin
                chk(0, "R2/R3/R7 unexpected strobe", {reg_rd, reg_wr}, 0);
            end else begin
                int k, i;
                k = exp_kind_q.pop_front();
                i = exp_idx_q.pop_front();
                chk(int'({reg_rd, reg_wr}) == k, "R2 strobe kind", {reg_rd, reg_wr}, k);
                chk(int'(reg_idx) == i, "R2 strobe index", reg_idx, i);
            end
        end
    end

    task automatic strobe_edge(input logic [1:0] a, input logic [1:0] sz,
                               input logic rd, input bit accept);
        @(negedge bclk);
        sel_n = 1'b0; addr = a; size = sz; rd_nwr = rd;
        @(negedge bclk);
        as_n = 1'b0;
        if (accept) begin
            accepted++;
            if (sz == 2'b00) begin
                legal++;
                exp_kind_q.push_back(rd ? 2 : 1);
                exp_idx_q.push_back(a);
                exp_code_q.push_back(6);
            end else begin
                exp_code_q.push_back(2);
            end
            exp_data_q.push_back(8'hA1 + a * 8'h11);
            exp_strb_q.push_back(legal);
        end
        @(negedge bclk);
        as_n = 1'b1; sel_n = 1'b1;
    endtask

    task automatic settle();
        int n = 0;
        while (acks < accepted && n < 400) begin
            @(negedge bclk);
            n++;
        end
        chk(acks == accepted, "R1 ack arrived", acks, accepted);
        repeat (40) @(negedge bclk);
    endtask

    initial begin
        repeat (3) @(negedge bclk);
        chk(reg_rd == 0 && reg_wr == 0, "R9 strobes in reset", {reg_rd, reg_wr}, 0);
        chk(ack_oe == 0, "R9 oe in reset", ack_oe, 0);
        chk(ack_code == 3'b111, "R9 code in reset", ack_code, 7);
        brst_n = 1'b1; irst_n = 1'b1;
        // R6: edge inside the power-up window is ignored
        strobe_edge(2'd1, 2'b00, 1'b1, 0);
        repeat (60) @(negedge bclk);
        chk(acks == 0, "R6 early access ignored", acks, 0);
        chk(strobes == 0, "R6 no early strobe", strobes, 0);

        strobe_edge(2'd0, 2'b00, 1'b1, 1); settle();   // R2 read reg 0
        strobe_edge(2'd2, 2'b00, 1'b0, 1); settle();   // R2 write reg 2
        strobe_edge(2'd3, 2'b00, 1'b1, 1); settle();   // R8 reg 3
        strobe_edge(2'd1, 2'b10, 1'b1, 1); settle();   // R3 illegal size
        strobe_edge(2'd2, 2'b01, 1'b0, 1); settle();   // R3 illegal write

        // R1: falling as_n with select high
        @(negedge bclk); sel_n = 1'b1; addr = 2'd1;
        @(negedge bclk); as_n = 1'b0;
        @(negedge bclk); as_n = 1'b1;
        // R1: select falls while strobe already low
        @(negedge bclk); as_n = 1'b0;
        @(negedge bclk); sel_n = 1'b0;
        repeat (2) @(negedge bclk);
        sel_n = 1'b1; as_n = 1'b1;
        repeat (60) @(negedge bclk);
        chk(acks == accepted, "R1 no-start patterns ignored", acks, accepted);

        // R7: second edge while first access in flight
        strobe_edge(2'd1, 2'b00, 1'b0, 1);
        repeat (2) @(negedge bclk);
        strobe_edge(2'd3, 2'b00, 1'b1, 0);
        settle();
        chk(strobes == legal, "R7 busy edge gave no strobe", strobes, legal);

        strobe_edge(2'd3, 2'b00, 1'b0, 1); settle();   // R7 accepted again afterwards
        chk(exp_code_q.size() == 0, "R5 all acks consumed", exp_code_q.size(), 0);
        chk(exp_kind_q.size() == 0, "R2 all strobes seen", exp_kind_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(BCLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule